// File: doc/BRIEF.md
# Program Memory Page Programming Controller

This block carries out the store-to-program-memory instruction for a program store that is organised in pages of 16-bit words. The core presents the instruction word, a 2-bit operation select, a 24-bit byte pointer and a data word from a register pair. The pointer is an 8-bit extension byte joined to the 16-bit Z pointer. The block then does one of three things. It erases one page to all-ones. It places one word into a temporary page buffer. Or it commits the whole buffer to a page in one pass. While it works it drives the write port of the program store and reads the old contents back through the same address.

The pointer is split as follows. Bit 0 is the byte select and the block ignores it. The next IDX_W = log2(PAGE_WORDS) bits give the word within the page. All bits above them give the page number. The post-increment opcode also returns Z + 2 to the core so that the pointer can be written back.

The sequencer has five states:
- `ST_IDLE`: waits for an accepted command. It moves to `ST_ERASE` for an erase, to `ST_PROG` for a page write, and to `ST_FINISH` for a buffer load.
- `ST_ERASE` and `ST_PROG`: step through every word of the page, one word per cycle. After the last word they move to `ST_SETTLE`, or straight to `ST_FINISH` when SETTLE_CYCLES is 0.
- `ST_SETTLE`: counts SETTLE_CYCLES cycles, then moves to `ST_FINISH`.
- `ST_FINISH`: raises done for one cycle, then always returns to `ST_IDLE`.

Top module: `spm_ctrl`

## Requirements
- R1: After reset, busy, done, prog_err, z_we and fl_we are all low.
- R2: A command is accepted only when issue is high, the block is idle, opcode is 0x95E8 or 0x95F8, and op_sel is 00 (erase), 01 (buffer load) or 10 (page write). Any other opcode, or op_sel 11, has no effect: busy stays low and neither the buffer nor the store changes.
- R3: A buffer load writes {data_hi, data_lo} into buffer word ptr_z[IDX_W:1], with data_hi as the upper byte. Busy and done are both high in the single cycle after acceptance.
- R4: An erase sets every word of page ptr[23:IDX_W+1] to 0xFFFF. It leaves every other page unchanged, and the word-index bits of the pointer have no effect on it.
- R5: A page write to an erased page stores each buffer word at the matching word of the addressed page, and prog_err stays low.
- R6: A page write to a page that holds any word other than 0xFFFF stores the bitwise AND of the old word and the buffer word. In that case prog_err is high when done rises and stays high until the next accepted command.
- R7: After every erase and after every page write, the page buffer holds 0xFFFF in all words.
- R8: An erase or page write keeps busy high for exactly PAGE_WORDS + SETTLE_CYCLES + 1 cycles. Done is high only in the last of those cycles.
- R9: Opcode 0x95F8 pulses z_we in the cycle after acceptance, with z_next = (ptr_z + 2) mod 2^16. Opcode 0x95E8 never raises z_we.
- R10: A command issued while busy is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| issue | input | 1 | Instruction present this cycle |
| opcode | input | 16 | Instruction word |
| op_sel | input | 2 | 00 erase, 01 buffer load, 10 page write |
| ptr_ext | input | 8 | Pointer extension byte (bits 23:16) |
| ptr_z | input | 16 | Z pointer (bits 15:0) |
| data_hi | input | 8 | Upper byte of the word to load |
| data_lo | input | 8 | Lower byte of the word to load |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| prog_err | output | 1 | Last page write hit a non-erased page |
| z_we | output | 1 | Write z_next back to Z |
| z_next | output | 16 | Post-incremented Z |
| fl_we | output | 1 | Program store write enable |
| fl_addr | output | 23 | Program store word address |
| fl_wdata | output | 16 | Program store write data |
| fl_rdata | input | 16 | Program store read data at fl_addr, same cycle |

## Verification
The assertions assume that the program store returns the word at fl_addr in the same cycle. They also assume that the core does not change the addressed page through any other path while an operation runs. The bench meets both conditions with a combinational-read array model that only this block writes after the preload phase. The assertions also rely on load, clear and accept never falling in the same cycle, which the sequencer itself guarantees. The bench deliberately drives some stimulus outside the legal envelope: illegal opcodes, op_sel 11, and an erase issued in the middle of a write. It then checks at the ports that none of these reached the store or the buffer.

// File: rtl/spm_pkg.sv
package spm_pkg;

    typedef enum logic [1:0] {
        OP_ERASE = 2'b00,
        OP_LOAD  = 2'b01,
        OP_WRITE = 2'b10
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ERASE,
        ST_PROG,
        ST_SETTLE,
        ST_FINISH
    } state_e;

    localparam logic [15:0] OPC_KEEP_Z = 16'h95E8;
    localparam logic [15:0] OPC_BUMP_Z = 16'h95F8;
    localparam logic [15:0] WORD_BLANK = 16'hFFFF;

endpackage

// File: rtl/spm_decode.sv
module spm_decode
    import spm_pkg::*;
(
    input  logic        issue,
    input  logic [15:0] opcode,
    input  logic [1:0]  op_sel,
    output logic        cmd_valid,
    output op_e         cmd_op,
    output logic        cmd_inc
);

    logic opc_hit;

    always_comb begin
        opc_hit   = (opcode == OPC_KEEP_Z) || (opcode == OPC_BUMP_Z);
        cmd_inc   = (opcode == OPC_BUMP_Z);
        cmd_op    = op_e'(op_sel);
        cmd_valid = issue && opc_hit && (op_sel != 2'b11);
    end

endmodule

// File: rtl/spm_page_buf.sv
module spm_page_buf
    import spm_pkg::*;
#(
    parameter  int PAGE_WORDS = 64,
    localparam int IDX_W      = $clog2(PAGE_WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_en,
    input  logic [IDX_W-1:0] ld_idx,
    input  logic [15:0]      ld_data,
    input  logic             clr,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [15:0]      rd_data
);

    logic [PAGE_WORDS-1:0][15:0] words;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < PAGE_WORDS; i++) words[i] <= WORD_BLANK;
        end else if (clr) begin
            for (int i = 0; i < PAGE_WORDS; i++) words[i] <= WORD_BLANK;
        end else if (ld_en) begin
            for (int i = 0; i < PAGE_WORDS; i++) begin
                if (ld_idx == IDX_W'(i)) words[i] <= ld_data;
            end
        end
    end

    assign rd_data = words[rd_idx];

    // R7: after a clear every word reads blank, whichever index is selected
    assert_clear_blank_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (rd_data == WORD_BLANK));

endmodule

// File: rtl/spm_seq.sv
module spm_seq
    import spm_pkg::*;
#(
    parameter  int PAGE_WORDS    = 64,
    parameter  int SETTLE_CYCLES = 16,
    parameter  int PTR_W         = 24,
    localparam int IDX_W         = $clog2(PAGE_WORDS),
    localparam int PAGE_W        = PTR_W - 1 - IDX_W,
    localparam int CNT_MAX       = (PAGE_WORDS > SETTLE_CYCLES) ? PAGE_WORDS : SETTLE_CYCLES,
    localparam int CNT_W         = $clog2(CNT_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  op_e               cmd_op,
    input  logic              cmd_inc,
    input  logic [PTR_W-1:0]  ptr,
    input  logic [15:0]       fl_rdata,
    output state_e            state,
    output logic [IDX_W-1:0]  idx,
    output logic [PAGE_W-1:0] page,
    output logic              busy,
    output logic              done,
    output logic              fl_we,
    output logic              buf_ld,
    output logic              buf_clr,
    output logic              prog_err,
    output logic              z_we,
    output logic [15:0]       z_next
);

    localparam logic [CNT_W-1:0] LAST_WORD   = CNT_W'(PAGE_WORDS - 1);
    localparam logic [CNT_W-1:0] LAST_SETTLE = CNT_W'((SETTLE_CYCLES > 0) ? SETTLE_CYCLES - 1 : 0);

    state_e            state_nxt;
    state_e            after_fill;
    logic [CNT_W-1:0]  cnt;
    op_e               op_q;
    logic [PAGE_W-1:0] page_q;
    logic              err_q;
    logic              z_we_q;
    logic [15:0]       z_next_q;
    logic              accept;

    generate
        if (SETTLE_CYCLES == 0) begin : g_no_settle
            assign after_fill = ST_FINISH;
        end else begin : g_settle
            assign after_fill = ST_SETTLE;
        end
    endgenerate

    assign accept = (state == ST_IDLE) && cmd_valid;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (cmd_valid) begin
                    unique case (cmd_op)
                        OP_ERASE: state_nxt = ST_ERASE;
                        OP_WRITE: state_nxt = ST_PROG;
                        default:  state_nxt = ST_FINISH;
                    endcase
                end
            end
            ST_ERASE,
            ST_PROG:   if (cnt == LAST_WORD)   state_nxt = after_fill;
            ST_SETTLE: if (cnt == LAST_SETTLE) state_nxt = ST_FINISH;
            ST_FINISH: state_nxt = ST_IDLE;
            default:   state_nxt = ST_IDLE;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        busy    = (state != ST_IDLE);
        done    = (state == ST_FINISH);
        fl_we   = (state == ST_ERASE) || (state == ST_PROG);
        buf_clr = (state == ST_FINISH) && (op_q != OP_LOAD);
        buf_ld  = accept && (cmd_op == OP_LOAD);
    end

    // counters and captured command fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            op_q     <= OP_LOAD;
            page_q   <= '0;
            err_q    <= 1'b0;
            z_we_q   <= 1'b0;
            z_next_q <= '0;
        end else begin
            cnt    <= (state_nxt != state) ? '0 : cnt + 1'b1;
            z_we_q <= accept && cmd_inc;
            if (accept) begin
                op_q     <= cmd_op;
                page_q   <= ptr[PTR_W-1:IDX_W+1];
                err_q    <= 1'b0;
                z_next_q <= ptr[15:0] + 16'd2;
            end else if ((state == ST_PROG) && (fl_rdata != WORD_BLANK)) begin
                err_q <= 1'b1;
            end
        end
    end

    assign idx      = cnt[IDX_W-1:0];
    assign page     = page_q;
    assign prog_err = err_q;
    assign z_we     = z_we_q;
    assign z_next   = z_next_q;

    // R8: completion is a single-cycle pulse
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: a pointer write-back only follows an accepted command
    assert_zwe_after_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        z_we |-> ($past(state) == ST_IDLE) && $past(cmd_valid));

    // R6: the error flag only moves on accept or while programming
    assert_err_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && (state != ST_PROG) && ($past(state) != ST_PROG))
            |-> $stable(prog_err));

endmodule

// File: rtl/spm_ctrl.sv
module spm_ctrl
    import spm_pkg::*;
#(
    parameter  int PAGE_WORDS    = 64,
    parameter  int SETTLE_CYCLES = 16,
    localparam int PTR_W         = 24,
    localparam int FA_W          = PTR_W - 1,
    localparam int IDX_W         = $clog2(PAGE_WORDS),
    localparam int PAGE_W        = FA_W - IDX_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            issue,
    input  logic [15:0]     opcode,
    input  logic [1:0]      op_sel,
    input  logic [7:0]      ptr_ext,
    input  logic [15:0]     ptr_z,
    input  logic [7:0]      data_hi,
    input  logic [7:0]      data_lo,
    output logic            busy,
    output logic            done,
    output logic            prog_err,
    output logic            z_we,
    output logic [15:0]     z_next,
    output logic            fl_we,
    output logic [FA_W-1:0] fl_addr,
    output logic [15:0]     fl_wdata,
    input  logic [15:0]     fl_rdata
);

    logic              cmd_valid;
    op_e               cmd_op;
    logic              cmd_inc;
    state_e            state;
    logic [IDX_W-1:0]  idx;
    logic [PAGE_W-1:0] page;
    logic              buf_ld;
    logic              buf_clr;
    logic [15:0]       buf_rd;
    logic [PTR_W-1:0]  ptr;

    assign ptr = {ptr_ext, ptr_z};

    spm_decode u_decode (
        .issue     (issue),
        .opcode    (opcode),
        .op_sel    (op_sel),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_inc   (cmd_inc)
    );

    spm_seq #(
        .PAGE_WORDS    (PAGE_WORDS),
        .SETTLE_CYCLES (SETTLE_CYCLES),
        .PTR_W         (PTR_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_inc   (cmd_inc),
        .ptr       (ptr),
        .fl_rdata  (fl_rdata),
        .state     (state),
        .idx       (idx),
        .page      (page),
        .busy      (busy),
        .done      (done),
        .fl_we     (fl_we),
        .buf_ld    (buf_ld),
        .buf_clr   (buf_clr),
        .prog_err  (prog_err),
        .z_we      (z_we),
        .z_next    (z_next)
    );

    spm_page_buf #(
        .PAGE_WORDS (PAGE_WORDS)
    ) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_en   (buf_ld),
        .ld_idx  (ptr_z[IDX_W:1]),
        .ld_data ({data_hi, data_lo}),
        .clr     (buf_clr),
        .rd_idx  (idx),
        .rd_data (buf_rd)
    );

    assign fl_addr  = {page, idx};
    assign fl_wdata = (state == ST_PROG) ? (fl_rdata & buf_rd) : WORD_BLANK;

    // R4: one operation never strays off its page
    assert_page_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(fl_addr[FA_W-1:IDX_W]));

endmodule

// File: tb/spm_ctrl_tb.sv
module spm_ctrl_tb;

    localparam int PW   = 8;
    localparam int ST   = 3;
    localparam int NP   = 4;
    localparam int NW   = PW * NP;
    localparam int OPLEN = PW + ST + 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue = 1'b0;
    logic [15:0] opcode = '0;
    logic [1:0]  op_sel = '0;
    logic [7:0]  ptr_ext = '0;
    logic [15:0] ptr_z = '0;
    logic [7:0]  data_hi = '0;
    logic [7:0]  data_lo = '0;
    logic        busy, done, prog_err, z_we, fl_we;
    logic [15:0] z_next, fl_wdata, fl_rdata;
    logic [22:0] fl_addr;

    logic        pre_we = 1'b0;
    logic [4:0]  pre_a = '0;
    logic [15:0] pre_d = '0;
    logic [15:0] fmem [NW];
    logic [15:0] ref_mem [NW];
    logic [15:0] buf_ref [PW];

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    spm_ctrl #(.PAGE_WORDS(PW), .SETTLE_CYCLES(ST)) u_dut (
        .clk(clk), .rst_n(rst_n), .issue(issue), .opcode(opcode), .op_sel(op_sel),
        .ptr_ext(ptr_ext), .ptr_z(ptr_z), .data_hi(data_hi), .data_lo(data_lo),
        .busy(busy), .done(done), .prog_err(prog_err), .z_we(z_we), .z_next(z_next),
        .fl_we(fl_we), .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_rdata(fl_rdata)
    );

    always_ff @(posedge clk) begin
        if (pre_we)     fmem[pre_a] <= pre_d;
        else if (fl_we) fmem[fl_addr[4:0]] <= fl_wdata;
    end
    assign fl_rdata = fmem[fl_addr[4:0]];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] pat(input int p, input int w);
        return 16'((p * 16'h2111 + w * 16'h0313) ^ 16'hA55A);
    endfunction

    task automatic do_op(input logic [15:0] opc, input logic [1:0] sel, input logic [15:0] z,
                         input logic [15:0] d, input bit intrude,
                         output int cyc, output int ndone, output bit err_d,
                         output int nzwe, output logic [15:0] zval);
        @(negedge clk);
        opcode = opc; op_sel = sel; ptr_z = z; data_hi = d[15:8]; data_lo = d[7:0];
        issue = 1'b1;
        @(negedge clk);
        issue = 1'b0;
        cyc = 0; ndone = 0; err_d = 1'b0; nzwe = 0; zval = '0;
        while (busy && cyc < 1000) begin
            if (done) begin ndone++; err_d = prog_err; end
            if (z_we) begin nzwe++; zval = z_next; end
            if (intrude && cyc == 3) begin
                opcode = 16'h95E8; op_sel = 2'b00; ptr_z = 16'h0000; issue = 1'b1;
            end
            if (intrude && cyc == 4) issue = 1'b0;
            cyc++;
            @(negedge clk);
        end
        issue = 1'b0;
    endtask

    task automatic t_erase(input int p, input int wbits);
        int cyc, nd, nz; bit e; logic [15:0] zv;
        do_op(16'h95E8, 2'b00, 16'(p * 16 + wbits * 2), 16'h0, 1'b0, cyc, nd, e, nz, zv);
        chk(cyc == OPLEN, "R8", "erase busy cycles", cyc, OPLEN);
        chk(nd == 1, "R8", "erase done pulses", nd, 1);
        for (int w = 0; w < PW; w++) ref_mem[p * PW + w] = 16'hFFFF;
        for (int w = 0; w < PW; w++) buf_ref[w] = 16'hFFFF;
    endtask

    task automatic t_load(input int w, input logic [15:0] d, input bit inc, input logic [15:0] zhi);
        int cyc, nd, nz; bit e; logic [15:0] zv; logic [15:0] z;
        z = zhi | 16'(w * 2);
        do_op(inc ? 16'h95F8 : 16'h95E8, 2'b01, z, d, 1'b0, cyc, nd, e, nz, zv);
        chk(cyc == 1 && nd == 1, "R3", "load busy/done cycles", cyc, 1);
        if (inc) begin
            chk(nz == 1, "R9", "z_we pulses", nz, 1);
            chk(zv == 16'(z + 16'd2), "R9", "z_next", zv, 16'(z + 16'd2));
        end else begin
            chk(nz == 0, "R9", "z_we on plain opcode", nz, 0);
        end
        buf_ref[w] = d;
    endtask

    task automatic t_write(input int p, input bit exp_err, input bit intrude);
        int cyc, nd, nz; bit e; logic [15:0] zv;
        do_op(16'h95E8, 2'b10, 16'(p * 16), 16'h0, intrude, cyc, nd, e, nz, zv);
        chk(cyc == OPLEN, "R8", "write busy cycles", cyc, OPLEN);
        chk(nd == 1, "R8", "write done pulses", nd, 1);
        chk(e == exp_err, exp_err ? "R6" : "R5", "prog_err at done", e, exp_err);
        chk(prog_err == exp_err, "R6", "prog_err held after done", prog_err, exp_err);
        for (int w = 0; w < PW; w++) ref_mem[p * PW + w] = ref_mem[p * PW + w] & buf_ref[w];
        for (int w = 0; w < PW; w++) buf_ref[w] = 16'hFFFF;
    endtask

    task automatic t_illegal(input logic [15:0] opc, input logic [1:0] sel, input logic [15:0] z);
        bit seen;
        @(negedge clk);
        opcode = opc; op_sel = sel; ptr_z = z; data_hi = 8'h00; data_lo = 8'h00; issue = 1'b1;
        @(negedge clk);
        issue = 1'b0;
        seen = busy;
        @(negedge clk);
        seen = seen | busy | done;
        chk(!seen, "R2", "illegal command raised busy", seen, 0);
    endtask

    task automatic check_flash(input string req);
        for (int i = 0; i < NW; i++)
            chk(fmem[i] == ref_mem[i], req, $sformatf("store word %0d", i), fmem[i], ref_mem[i]);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int w = 0; w < PW; w++) buf_ref[w] = 16'hFFFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!busy, "R1", "busy", busy, 0);
        chk(!done, "R1", "done", done, 0);
        chk(!prog_err, "R1", "prog_err", prog_err, 0);
        chk(!z_we, "R1", "z_we", z_we, 0);
        chk(!fl_we, "R1", "fl_we", fl_we, 0);

        // preload non-blank contents
        for (int i = 0; i < NW; i++) begin
            pre_we = 1'b1; pre_a = 5'(i); pre_d = 16'(i * 16'h0F0F ^ 16'h1234);
            ref_mem[i] = pre_d;
            @(negedge clk);
        end
        pre_we = 1'b0;

        // R2: malformed commands do nothing
        t_illegal(16'h95E9, 2'b00, 16'h0000);
        t_illegal(16'h9508, 2'b00, 16'h0010);
        t_illegal(16'h95F8, 2'b11, 16'h0000);
        t_illegal(16'h85E8, 2'b10, 16'h0020);
        check_flash("R2");

        // R4: erase each page, word bits varied
        for (int p = 0; p < NP; p++) t_erase(p, (p * 3 + 1) % PW);
        check_flash("R4");

        // R5: program pages 0 and 1; R10 intrusion during page 1 write
        for (int w = 0; w < PW; w++) t_load(w, pat(0, w), w[0], 16'h0000);
        t_write(0, 1'b0, 1'b0);
        for (int w = 0; w < PW; w++) t_load(w, pat(1, w), !w[0], 16'h3300);
        t_write(1, 1'b0, 1'b1);
        check_flash("R10");

        // R7: buffer blank after write; R2 illegal load ignored
        t_illegal(16'h95E9, 2'b01, 16'h0000);
        t_write(2, 1'b0, 1'b0);
        check_flash("R7");

        // R6: partial rewrite of programmed page 0
        for (int w = 0; w < 4; w++) t_load(w, ~(16'h0001 << w), 1'b0, 16'h0000);
        t_write(0, 1'b1, 1'b0);
        check_flash("R6");

        // R9 wrap, then R7 buffer blank after erase
        t_load(PW - 1, 16'h0000, 1'b1, 16'hFFF0);
        t_erase(3, 0);
        t_write(3, 1'b0, 1'b0);
        check_flash("R7");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule